// File: doc/BRIEF.md
# Auxiliary SAR Converter Sequencer

This block drives an 8-bit successive-approximation converter used for slow housekeeping measurements such as supply and temperature. One of four analog inputs is chosen through an external multiplexer. The block presents a trial code to a DAC, reads back a single comparator decision per step, and builds the result from the most significant bit down. It then sends the finished code out on a serial data line with its own serial clock. While enabled it converts continuously, one result after another. When disabled it is powered down and both serial lines sit low.

The channel index comes from one of two sources. It can come from two select pins, or from two register bits when an override flag is set. The chosen index is captured once, at the start of each conversion. One serial clock period (`2*HALF_DIV` system clocks) paces both each trial step and each serial bit. This gives a frame of `2*RES_W` such periods.

Top module: `auxsar_ctrl`

## Requirements
- R1: Each conversion starts with the trial code at half scale (only the MSB set). After each step the bit under test is kept when `cmp_i` is 1 and cleared when it is 0, and the next lower bit is set. The steps run from the MSB to the LSB, one per serial clock period.
- R2: With a comparator that returns 1 when the analog level is greater than or equal to the trial code, the result sent is the analog level itself, for every code from 0 to 255.
- R3: When `sel_ovr_i` is 0, the channel index on `ch_sel_o` (0 to 3, binary) comes from `sel_pin_i`. When `sel_ovr_i` is 1 it comes from `sel_reg_i`, and the unused source has no effect on the result.
- R4: The channel index is captured in the first cycle of a conversion and held until the next conversion starts. A change on the select inputs during a conversion only affects the following one.
- R5: The result is sent MSB first, one bit per serial clock period. `ser_dout_o` changes only while `ser_clk_o` is low and stays stable across each rising edge of `ser_clk_o`.
- R6: Within a serial bit, `ser_clk_o` is low for `HALF_DIV` system clocks and then high for `HALF_DIV` clocks. Rising edges are `2*HALF_DIV` clocks apart.
- R7: While `conv_en_i` stays high, frames follow each other with no gap. The first rising serial clock edges of consecutive frames are `2*RES_W*2*HALF_DIV` clocks apart.
- R8: If `conv_en_i` is low at a clock edge, then after that edge `ser_clk_o`, `ser_dout_o` and `dac_code_o` are all 0, including in the middle of a conversion. They stay 0 while it remains low.
- R9: After `conv_en_i` rises, a fresh conversion begins at the next edge. The first rising serial clock edge follows `1 + RES_W*2*HALF_DIV + HALF_DIV` clock edges after enable is sampled high.
- R10: After synchronous reset with enable low, `ser_clk_o`, `ser_dout_o` and `dac_code_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en_i | input | 1 | Converter enable; low powers the block down |
| sel_pin_i | input | SEL_W | Channel select from pins |
| sel_reg_i | input | SEL_W | Channel select from register bits |
| sel_ovr_i | input | 1 | 1 selects the register bits, 0 selects the pins |
| cmp_i | input | 1 | Comparator decision: analog level >= trial code |
| ch_sel_o | output | SEL_W | Channel index to the analog multiplexer |
| dac_code_o | output | RES_W | Trial code to the DAC, 0 outside the trial steps |
| ser_dout_o | output | 1 | Serial result data |
| ser_clk_o | output | 1 | Serial result clock |

## Verification
The serial bit of the last result finishes in the same clock edge that starts the next conversion. That edge captures the new channel and loads the half-scale trial code. The bench provokes this edge on every frame of a continuous run, changing the analog levels and select inputs just after the last rising serial edge. Each received frame must then match the level of the channel selected for that frame. The frame spacing must stay exactly one frame period, so a lost or shared cycle at the boundary shows up as a wrong code or a wrong spacing. A separate case changes the pins in the middle of a conversion and expects the old channel for that frame and the new one for the next.

// File: rtl/auxsar_pkg.sv
package auxsar_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_CONV  = 2'd1,
        SEQ_SHIFT = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic start;
        logic step;
        logic load;
        logic shift;
    } seq_ctl_t;

    function automatic int unsigned cnt_width(int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/auxsar_bit_timer.sv
module auxsar_bit_timer #(
    parameter int HALF_DIV = 24,
    parameter int CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             bit_end_o,
    output logic             high_half_o
);
    localparam int BIT_CYC = 2 * HALF_DIV;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(BIT_CYC - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o       = cnt_q;
    assign bit_end_o   = (cnt_q == CNT_W'(BIT_CYC - 1));
    assign high_half_o = (cnt_q >= CNT_W'(HALF_DIV));

endmodule

// File: rtl/auxsar_chan_latch.sv
module auxsar_chan_latch #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEL_W-1:0] pin_sel,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             ovr,
    output logic [SEL_W-1:0] ch_o
);
    logic [SEL_W-1:0] ch_q;
    logic [SEL_W-1:0] pick;

    assign pick = ovr ? reg_sel : pin_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q <= '0;
        end else if (load) begin
            ch_q <= pick;
        end
    end

    assign ch_o = ch_q;

endmodule

// File: rtl/auxsar_sar_core.sv
module auxsar_sar_core #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start,
    input  logic             step,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] decided_o,
    output logic             last_o
);
    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] trial_q;
    logic [RES_W-1:0] mask_q;
    logic [RES_W-1:0] kept;
    logic [RES_W-1:0] mask_nx;

    always_comb begin
        kept    = cmp_i ? trial_q : (trial_q & ~mask_q);
        mask_nx = mask_q >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            trial_q <= '0;
            mask_q  <= '0;
        end else if (start) begin
            trial_q <= TOP_BIT;
            mask_q  <= TOP_BIT;
        end else if (step) begin
            trial_q <= kept | mask_nx;
            mask_q  <= mask_nx;
        end
    end

    assign trial_o   = trial_q;
    assign decided_o = kept;
    assign last_o    = mask_q[0];

endmodule

// File: rtl/auxsar_shifter.sv
module auxsar_shifter #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [RES_W-1:0] load_val,
    input  logic             shift,
    output logic             bit_o,
    output logic             last_o
);
    localparam int REM_W = auxsar_pkg::cnt_width(RES_W + 1);

    logic [RES_W-1:0] sh_q;
    logic [REM_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            rem_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            rem_q <= REM_W'(RES_W);
        end else if (shift) begin
            sh_q  <= {sh_q[RES_W-2:0], 1'b0};
            rem_q <= (rem_q == '0) ? rem_q : rem_q - 1'b1;
        end
    end

    assign bit_o  = sh_q[RES_W-1];
    assign last_o = (rem_q == REM_W'(1));

endmodule

// File: rtl/auxsar_ctrl.sv
module auxsar_ctrl
    import auxsar_pkg::*;
#(
    parameter int RES_W    = 8,
    parameter int SEL_W    = 2,
    parameter int HALF_DIV = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_en_i,
    input  logic [SEL_W-1:0] sel_pin_i,
    input  logic [SEL_W-1:0] sel_reg_i,
    input  logic             sel_ovr_i,
    input  logic             cmp_i,
    output logic [SEL_W-1:0] ch_sel_o,
    output logic [RES_W-1:0] dac_code_o,
    output logic             ser_dout_o,
    output logic             ser_clk_o
);
    localparam int BIT_CYC = 2 * HALF_DIV;
    localparam int CNT_W   = cnt_width(BIT_CYC);

    seq_state_t       state_q, state_d;
    seq_ctl_t         ctl;
    logic             start_w;
    logic [CNT_W-1:0] bit_cnt_w;
    logic             bit_end;
    logic             high_half;
    logic             timer_clr;
    logic [RES_W-1:0] trial;
    logic [RES_W-1:0] decided;
    logic             sar_last;
    logic             sh_bit;
    logic             sh_last;

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        if (!conv_en_i) begin
            state_d = SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    ctl.start = 1'b1;
                    state_d   = SEQ_CONV;
                end
                SEQ_CONV: begin
                    if (bit_end) begin
                        ctl.step = 1'b1;
                        if (sar_last) begin
                            ctl.load = 1'b1;
                            state_d  = SEQ_SHIFT;
                        end
                    end
                end
                SEQ_SHIFT: begin
                    if (bit_end) begin
                        ctl.shift = 1'b1;
                        if (sh_last) begin
                            ctl.start = 1'b1;
                            state_d   = SEQ_CONV;
                        end
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign start_w   = ctl.start;
    assign timer_clr = !conv_en_i || (state_q == SEQ_IDLE);

    auxsar_bit_timer #(
        .HALF_DIV (HALF_DIV),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .clr         (timer_clr),
        .cnt_o       (bit_cnt_w),
        .bit_end_o   (bit_end),
        .high_half_o (high_half)
    );

    auxsar_chan_latch #(
        .SEL_W (SEL_W)
    ) u_chan (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.start),
        .pin_sel (sel_pin_i),
        .reg_sel (sel_reg_i),
        .ovr     (sel_ovr_i),
        .ch_o    (ch_sel_o)
    );

    auxsar_sar_core #(
        .RES_W (RES_W)
    ) u_sar (
        .clk       (clk),
        .rst       (rst),
        .clr       (!conv_en_i),
        .start     (ctl.start),
        .step      (ctl.step),
        .cmp_i     (cmp_i),
        .trial_o   (trial),
        .decided_o (decided),
        .last_o    (sar_last)
    );

    auxsar_shifter #(
        .RES_W (RES_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (!conv_en_i),
        .load     (ctl.load),
        .load_val (decided),
        .shift    (ctl.shift),
        .bit_o    (sh_bit),
        .last_o   (sh_last)
    );

    assign dac_code_o = (state_q == SEQ_CONV) ? trial : '0;
    assign ser_clk_o  = (state_q == SEQ_SHIFT) && high_half;
    assign ser_dout_o = (state_q == SEQ_SHIFT) && sh_bit;

endmodule

// File: rtl/auxsar_ctrl_chk.sv
module auxsar_ctrl_chk #(
    parameter int RES_W    = 8,
    parameter int SEL_W    = 2,
    parameter int HALF_DIV = 24,
    parameter int CNT_W    = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             sclk,
    input logic             dout,
    input logic [RES_W-1:0] dac,
    input logic [SEL_W-1:0] ch,
    input logic             start,
    input logic [CNT_W-1:0] bit_cnt
);
    localparam int BIT_CYC = 2 * HALF_DIV;
    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    // R8
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sclk && !dout && dac == '0));

    // R1
    msb_trial_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (dac == TOP_BIT));

    // R4
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(ch));

    // R5
    data_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(dout));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(bit_cnt) < BIT_CYC);

    // R6
    sclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (bit_cnt == '0));

endmodule

bind auxsar_ctrl auxsar_ctrl_chk #(
    .RES_W    (RES_W),
    .SEL_W    (SEL_W),
    .HALF_DIV (HALF_DIV),
    .CNT_W    (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (conv_en_i),
    .sclk    (ser_clk_o),
    .dout    (ser_dout_o),
    .dac     (dac_code_o),
    .ch      (ch_sel_o),
    .start   (start_w),
    .bit_cnt (bit_cnt_w)
);

// File: tb/auxsar_ctrl_tb.sv
module auxsar_ctrl_tb;
    localparam int RES_W = 8;
    localparam int SEL_W = 2;
    localparam int HALF  = 2;
    localparam int BIT   = 2 * HALF;
    localparam int FRAME = 2 * RES_W * BIT;

    logic             clk = 1'b0;
    logic             rst;
    logic             conv_en;
    logic [SEL_W-1:0] sel_pin;
    logic [SEL_W-1:0] sel_reg;
    logic             sel_ovr;
    logic             cmp;
    logic [SEL_W-1:0] ch_sel;
    logic [RES_W-1:0] dac_code;
    logic             ser_dout;
    logic             ser_clk;
    logic [7:0]       vin [0:3];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign cmp = (vin[ch_sel] >= dac_code);

    auxsar_ctrl #(.RES_W(RES_W), .SEL_W(SEL_W), .HALF_DIV(HALF)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .conv_en_i  (conv_en),
        .sel_pin_i  (sel_pin),
        .sel_reg_i  (sel_reg),
        .sel_ovr_i  (sel_ovr),
        .cmp_i      (cmp),
        .ch_sel_o   (ch_sel),
        .dac_code_o (dac_code),
        .ser_dout_o (ser_dout),
        .ser_clk_o  (ser_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic set_sel(input int ch, input bit ovr);
        sel_ovr = ovr;
        if (ovr) begin
            sel_reg = SEL_W'(ch);
            sel_pin = ~SEL_W'(ch);
        end else begin
            sel_pin = SEL_W'(ch);
            sel_reg = ~SEL_W'(ch);
        end
    endtask

    task automatic recv_frame(output logic [7:0] v, output int t0, output int hi,
                              output int bad_sp, output int chg);
        logic prev_c;
        logic prev_d;
        int   nb;
        int   last_t;
        v = 0; nb = 0; hi = 0; bad_sp = 0; chg = 0; t0 = 0; last_t = 0;
        prev_c = ser_clk;
        prev_d = ser_dout;
        while (nb < RES_W) begin
            @(negedge clk);
            if (ser_clk && prev_c && ser_dout != prev_d) chg++;
            if (ser_clk && !prev_c) begin
                if (nb == 0) t0 = cyc;
                else if (cyc - last_t != BIT) bad_sp++;
                last_t = cyc;
                v = {v[6:0], ser_dout};
                nb++;
            end
            if (ser_clk && nb > 0) hi++;
            prev_c = ser_clk;
            prev_d = ser_dout;
        end
    endtask

    task automatic trace(input logic [7:0] val);
        int n;
        int exp;
        @(negedge clk);
        conv_en = 0;
        repeat (3) @(negedge clk);
        vin[3] = val;
        set_sel(3, 1);
        conv_en = 1;
        @(negedge clk);
        chk(ch_sel == 2'd3, "R3 channel from register bits", int'(ch_sel), 3);
        for (int j = 0; j < RES_W; j++) begin
            if (j > 0) repeat (BIT) @(negedge clk);
            exp = (((int'(val) >> (8 - j)) << (8 - j)) & 255) | (128 >> j);
            chk(dac_code == 8'(exp), "R1 trial code step", int'(dac_code), exp);
        end
        n = 1 + (RES_W - 1) * BIT;
        while (!ser_clk && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(n == 1 + RES_W * BIT + HALF, "R9 first serial edge latency", n, 1 + RES_W * BIT + HALF);
        chk(ser_dout == val[7], "R5 first bit is MSB", int'(ser_dout), int'(val[7]));
        conv_en = 0;
        @(negedge clk);
        chk(!ser_clk && !ser_dout && dac_code == 0, "R8 abort outputs low",
            int'({ser_clk, ser_dout}) + int'(dac_code), 0);
        n = 0;
        repeat (6) begin
            @(negedge clk);
            if (ser_clk || ser_dout || dac_code != 0) n++;
        end
        chk(n == 0, "R8 outputs stay low while disabled", n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_v;
        int t0, hi, bad_sp, chg, prev_t;

        rst = 1; conv_en = 0; sel_pin = 0; sel_reg = 0; sel_ovr = 0;
        for (int c = 0; c < 4; c++) vin[c] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!ser_clk && !ser_dout && dac_code == 0, "R10 reset state",
            int'({ser_clk, ser_dout}) + int'(dac_code), 0);

        trace(8'h00);
        trace(8'hFF);
        trace(8'hA5);
        trace(8'h80);
        trace(8'h7F);
        trace(8'h01);

        @(negedge clk);
        conv_en = 0;
        repeat (3) @(negedge clk);
        exp_v = 0;
        prev_t = 0;
        for (int i = 0; i < 1024; i++) begin
            if (i == 0 || i > 0) begin
                if (i == 0) begin
                    for (int c = 0; c < 4; c++) vin[c] = 8'((0 + 67 * c) & 255);
                    set_sel(0, 0);
                    exp_v = vin[0];
                    conv_en = 1;
                end
            end
            recv_frame(v, t0, hi, bad_sp, chg);
            chk(v == exp_v, "R2 R3 frame value", int'(v), int'(exp_v));
            chk(chg == 0, "R5 data stable while clock high", chg, 0);
            if (i > 0) chk(t0 - prev_t == FRAME, "R7 frame spacing", t0 - prev_t, FRAME);
            if (i < 4) chk(hi == (RES_W - 1) * HALF + 1 && bad_sp == 0,
                           "R6 serial clock shape", hi, (RES_W - 1) * HALF + 1);
            prev_t = t0;
            if (i < 1023) begin
                for (int c = 0; c < 4; c++)
                    vin[c] = 8'(((((i + 1) >> 2) & 255) + 67 * c) & 255);
                set_sel((i + 1) & 3, ((i + 1) >> 2 & 1) == 1);
                exp_v = vin[(i + 1) & 3];
            end
        end

        vin[0] = 8'h11; vin[1] = 8'h22; vin[2] = 8'h33; vin[3] = 8'h44;
        set_sel(1, 0);
        repeat (6) @(negedge clk);
        set_sel(2, 0);
        chk(ch_sel == 2'd1, "R4 channel held mid-conversion", int'(ch_sel), 1);
        recv_frame(v, t0, hi, bad_sp, chg);
        chk(v == 8'h22, "R4 frame uses channel captured at start", int'(v), 8'h22);
        recv_frame(v, t0, hi, bad_sp, chg);
        chk(v == 8'h33, "R4 next frame uses new channel", int'(v), 8'h33);

        done = 1;
        summary();
        $finish;
    end

endmodule